// File: doc/BRIEF.md
# Rotation-Based Vector Intersection Mask Unit

This block takes two operand vectors of sixteen 32-bit unsigned elements, called A and B. It reports which elements of each vector also occur somewhere in the other vector. The main result, `ka_mask`, has one bit per A element. The optional second result, `kb_mask`, has one bit per B element. A typical use is the inner step of a set-intersection or intersection-count loop over sorted integer lists. There the caller compacts or counts the A elements whose bits are set.

The unit does not build a full 16x16 grid of comparators. It groups the lanes into blocks of four. A is swept through its four whole-block rotations, one per clock. In every one of those cycles, four 16-lane comparator banks compare the current A rotation with B rotated by 0, 1, 2 and 3 places inside each block of four. The partial hit masks are folded back into each operand's own lane order:

- The A-side accumulator rotates along with the A operand register, so it returns to natural order after the last pass.
- The B-side hits are kept per in-block rotation and un-shuffled once at the end.

A request is made with a one-cycle `start`. The operands and the `kb_en` choice are captured at that edge. A one-cycle `done` pulse marks new registered masks.

Top module: `isect_mask_unit`

## Requirements
- R1: After a run, `ka_mask` bit i is 1 exactly when A element i (bits 32i+31..32i of `vec_a`) equals at least one of the sixteen B elements.
- R2: After a run started with `kb_en`=1, `kb_mask` bit j is 1 exactly when B element j (bits 32j+31..32j of `vec_b`) equals at least one A element.
- R3: After a run started with `kb_en`=0, `kb_mask` reads all zeros while `ka_mask` is still computed.
- R4: A `start` sampled while idle sets `busy` from the next cycle on. `done` is then a single-cycle pulse that rises on the fourth rising edge after the accepting edge, and `busy` is low in that cycle.
- R5: A `start` sampled while `busy` is high is ignored: no extra `done` pulse follows, and the result belongs to the accepted operands.
- R6: Operands and `kb_en` are captured at the accepting edge. Input changes after that edge, or with no `start`, leave both masks unchanged until the next `done`.
- R7: While reset (`rst_n` low) is applied, `busy`, `done`, `ka_mask` and `kb_mask` all become 0.
- R8: Repeated values are handled per element. Every copy of a value present in the other vector gets its own bit set, so two all-equal vectors give 0xFFFF on both masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a run; honoured only while idle |
| kb_en | input | 1 | Also produce the B-side mask for this run |
| vec_a | input | 512 | Sixteen A elements, element i at bits 32i+31..32i |
| vec_b | input | 512 | Sixteen B elements, element j at bits 32j+31..32j |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: masks just updated |
| ka_mask | output | 16 | Bit i set when A element i occurs in B |
| kb_mask | output | 16 | Bit j set when B element j occurs in A (zero if not requested) |

## Verification
The bench targets matches that cross a block-of-four boundary, such as A lane 15 with B lane 0 and A lane 3 with B lane 12. A wrong rotation step or a wrong un-rotation would put those bits on the wrong lane or lose them. It also runs fully disjoint, fully equal and heavily duplicated vectors. Against these, an un-shuffle with a wrong constant, or a B mask taken from the wrong bank, would set spurious bits or miss copies. A second `start` during a run and operand changes while busy or idle expose a design that restarts, pulses `done` twice or samples its inputs live. A run without `kb_en` shows whether stale B-side hits leak onto `kb_mask`.

// File: rtl/isect_mask_unit.sv
module isect_mask_unit #(
  parameter int ELEM_W = 32,
  parameter int LANES  = 16,
  parameter int GROUP  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    kb_en,
  input  logic [LANES*ELEM_W-1:0] vec_a,
  input  logic [LANES*ELEM_W-1:0] vec_b,
  output logic                    busy,
  output logic                    done,
  output logic [LANES-1:0]        ka_mask,
  output logic [LANES-1:0]        kb_mask
);
  localparam int PASSES = LANES / GROUP;
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam int SHW    = GROUP * ELEM_W;

  logic [LANES*ELEM_W-1:0]     a_q, b_q;
  logic                        kb_q;
  logic [PW-1:0]               pass_q;
  logic [LANES-1:0]            ka_acc;
  logic [GROUP-1:0][LANES-1:0] mb_acc;

  logic [GROUP-1:0][LANES-1:0] eq;
  logic [GROUP-1:0][LANES-1:0] mb_next;
  logic [LANES-1:0]            any_hit, ka_merge, ka_next, kb_next;
  logic [LANES*ELEM_W-1:0]     a_rot;

  // one comparator bank per in-block rotation of B
  for (genvar r = 0; r < GROUP; r++) begin : g_bank
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int BI = (i / GROUP) * GROUP + ((i % GROUP) + r) % GROUP;
      assign eq[r][i] = a_q[i*ELEM_W +: ELEM_W] == b_q[BI*ELEM_W +: ELEM_W];
    end
  end

  always_comb begin
    any_hit = '0;
    for (int r = 0; r < GROUP; r++) begin
      any_hit    = any_hit | eq[r];
      mb_next[r] = mb_acc[r] | eq[r];
    end
  end

  // A and its accumulator advance together by one block of lanes per pass
  assign a_rot    = {a_q[SHW-1:0], a_q[LANES*ELEM_W-1:SHW]};
  assign ka_merge = ka_acc | any_hit;
  assign ka_next  = {ka_merge[GROUP-1:0], ka_merge[LANES-1:GROUP]};

  always_comb begin
    kb_next = '0;
    for (int r = 0; r < GROUP; r++)
      for (int i = 0; i < LANES; i++)
        if (mb_next[r][i])
          kb_next[(i / GROUP) * GROUP + ((i % GROUP) + r) % GROUP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      kb_q    <= 1'b0;
      pass_q  <= '0;
      ka_acc  <= '0;
      mb_acc  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      ka_mask <= '0;
      kb_mask <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        a_q    <= vec_a;
        b_q    <= vec_b;
        kb_q   <= kb_en;
        pass_q <= '0;
        ka_acc <= '0;
        mb_acc <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        a_q    <= a_rot;
        ka_acc <= ka_next;
        mb_acc <= mb_next;
        pass_q <= pass_q + 1'b1;
        if (pass_q == PW'(PASSES - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          ka_mask <= ka_next;
          kb_mask <= kb_q ? kb_next : '0;
        end
      end
    end
  end
endmodule

module isect_mask_unit_chk #(
  parameter int LANES  = 16,
  parameter int PASSES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             kb_en,
  input logic             busy,
  input logic             done,
  input logic [LANES-1:0] ka_mask,
  input logic [LANES-1:0] kb_mask
);
  logic [7:0] cnt;
  logic       kb_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      kb_cap <= 1'b0;
    end else if (start && !busy) begin
      cnt    <= 8'd1;
      kb_cap <= kb_en;
    end else if (busy) begin
      cnt <= cnt + 8'd1;
    end
  end

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == 8'(PASSES + 1));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_no_done_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (!done || cnt == 8'(PASSES + 1)));
  a_r6_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ka_mask) && $stable(kb_mask)));
  a_r3_kb_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !kb_cap) |-> kb_mask == '0);
  a_r7_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && ka_mask == '0 && kb_mask == '0));
endmodule

bind isect_mask_unit isect_mask_unit_chk #(.LANES(LANES), .PASSES(LANES / GROUP)) u_chk (.*);

// File: tb/isect_mask_unit_bench.sv
module isect_mask_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, kb_en = 1'b0;
  logic [N*32-1:0] vec_a = '0, vec_b = '0;
  logic busy, done;
  logic [N-1:0] ka_mask, kb_mask;

  int checks = 0, fails = 0;
  logic [31:0] av [N];
  logic [31:0] bv [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  isect_mask_unit u_isect_mask_unit (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [N-1:0] ref_ka();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (av[i] == bv[j]) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [N-1:0] ref_kb();
    logic [N-1:0] r = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        if (av[i] == bv[j]) r[j] = 1'b1;
    return r;
  endfunction

  task automatic load_ops();
    for (int i = 0; i < N; i++) begin
      vec_a[i*32 +: 32] = av[i];
      vec_b[i*32 +: 32] = bv[i];
    end
  endtask

  // run one request and check timing and both masks
  task automatic run(input logic ke, input string tag);
    logic [N-1:0] eka, ekb;
    eka = ref_ka();
    ekb = ke ? ref_kb() : '0;
    @(negedge clk);
    load_ops();
    kb_en = ke;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R4 busy"}, 32'(busy), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(done === 1'b0, {tag, " R4 early done"}, 32'(done), 32'd0);
    end
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, {tag, " R4 done"}, {30'd0, busy, done}, 32'd1);
    check(ka_mask === eka, {tag, " R1 ka"}, 32'(ka_mask), 32'(eka));
    check(kb_mask === ekb, {tag, ke ? " R2 kb" : " R3 kb off"}, 32'(kb_mask), 32'(ekb));
    @(negedge clk);
    check(done === 1'b0, {tag, " R4 pulse"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0, "R7 ctrl", {30'd0, busy, done}, 32'd0);
    check(ka_mask === '0 && kb_mask === '0, "R7 masks", {ka_mask, kb_mask}, 32'd0);
  endtask

  task automatic t_random();
    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < N; i++) begin
        av[i] = 32'($urandom_range(0, 23));
        bv[i] = 32'($urandom_range(0, 23));
      end
      run(1'b1, "random R1 R2");
    end
    for (int i = 0; i < N; i++) begin
      av[i] = $urandom;
      bv[i] = $urandom;
    end
    av[5] = bv[9];
    run(1'b1, "wide random");
  endtask

  task automatic t_boundary();
    for (int i = 0; i < N; i++) begin
      av[i] = 32'h1000 + 32'(i);
      bv[i] = 32'h2000 + 32'(i);
    end
    av[15] = 32'hAAAA0001; bv[0]  = 32'hAAAA0001;
    av[0]  = 32'hBBBB0002; bv[15] = 32'hBBBB0002;
    av[3]  = 32'hCCCC0003; bv[12] = 32'hCCCC0003;
    av[6]  = 32'hFFFFFFFF; bv[6]  = 32'hFFFFFFFF;
    run(1'b1, "cross-block R1 R2");
    check(ka_mask === 16'h8049, "R1 lanes", 32'(ka_mask), 32'h8049);
    check(kb_mask === 16'h9041, "R2 lanes", 32'(kb_mask), 32'h9041);
  endtask

  task automatic t_disjoint();
    for (int i = 0; i < N; i++) begin
      av[i] = 32'(2 * i);
      bv[i] = 32'(2 * i + 1);
    end
    run(1'b1, "disjoint R1 R2");
    check(ka_mask === '0 && kb_mask === '0, "R1 disjoint zero", {ka_mask, kb_mask}, 32'd0);
  endtask

  task automatic t_dupes();
    for (int i = 0; i < N; i++) begin
      av[i] = 32'd77;
      bv[i] = 32'd77;
    end
    run(1'b1, "all-equal R8");
    check(ka_mask === 16'hFFFF && kb_mask === 16'hFFFF, "R8 all-equal", {ka_mask, kb_mask}, 32'hFFFFFFFF);
    for (int i = 0; i < N; i++) begin
      av[i] = 32'(i % 3);
      bv[i] = (i < 2) ? 32'd1 : 32'd50 + 32'(i);
    end
    run(1'b1, "dupes R8");
    check(ka_mask === 16'h2492, "R8 every copy", 32'(ka_mask), 32'h2492);
  endtask

  task automatic t_kb_off();
    for (int i = 0; i < N; i++) begin
      av[i] = 32'd9;
      bv[i] = 32'd9;
    end
    run(1'b0, "kb off R3");
    check(ka_mask === 16'hFFFF, "R3 ka still computed", 32'(ka_mask), 32'hFFFF);
  endtask

  task automatic t_restart();
    logic [N-1:0] eka, ekb;
    for (int i = 0; i < N; i++) begin
      av[i] = 32'(i);
      bv[i] = 32'(i + 8);
    end
    eka = ref_ka();
    ekb = ref_kb();
    @(negedge clk);
    load_ops();
    kb_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) begin
      av[i] = 32'd5;
      bv[i] = 32'd5;
    end
    load_ops();
    kb_en = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done === 1'b1, "R5 done on time", 32'(done), 32'd1);
    check(ka_mask === eka, "R5 ka first operands", 32'(ka_mask), 32'(eka));
    check(kb_mask === ekb, "R6 kb first operands", 32'(kb_mask), 32'(ekb));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R5 no second run", {30'd0, busy, done}, 32'd0);
    end
  endtask

  task automatic t_hold();
    logic [N-1:0] ka0, kb0;
    ka0 = ka_mask;
    kb0 = kb_mask;
    for (int i = 0; i < N; i++) begin
      vec_a[i*32 +: 32] = 32'd3;
      vec_b[i*32 +: 32] = 32'd3;
    end
    kb_en = 1'b1;
    repeat (6) @(negedge clk);
    check(ka_mask === ka0 && kb_mask === kb0, "R6 hold idle", {ka_mask, kb_mask}, {ka0, kb0});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_boundary();
    t_random();
    t_disjoint();
    t_dupes();
    t_kb_off();
    t_restart();
    t_hold();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule